// File: doc/BRIEF.md
# Vector Shift-Left-and-Insert Unit

This block takes a source vector and the current contents of a destination vector and returns a new destination vector. Every source element is moved left by an immediate amount; the low bits left empty by that move are taken from the matching element of the old destination. The destination element therefore keeps its low bits, and the source supplies everything above them. Bits pushed past the top of an element are lost, and no bit ever crosses from one lane into another.

Element size and shift amount both come from one 7-bit immediate. The most significant set bit of the immediate gives the element size, and the bits below that set bit give the shift. A width select chooses between a 64-bit vector and a 128-bit vector. In 64-bit mode the upper half of the result is the old destination, copied through unchanged. An immediate whose top four bits are all zero has no valid size. Such an immediate is flagged, and the old destination is returned untouched.

The result is registered. It appears one cycle after the request, together with a valid strobe.

Top module: `sli_insert_unit`

## Requirements
- R1: For each element, the result is (source << shift), truncated to the element width, bitwise-ORed with (old destination AND a mask of the low `shift` bits).
- R2: A shift of zero gives an empty mask, so each result element equals its source element.
- R3: Immediate decode. If imm[6]=1, elements are 64 bits and shift = imm[5:0]. Otherwise the highest set bit among imm[5], imm[4] and imm[3] selects 32-, 16- or 8-bit elements, and the bits below that set bit give the shift. The shift is always below the element width.
- R4: Source bits shifted past the top of an element are dropped, and no lane changes any other lane.
- R5: When `wide_i`=1, all 128 bits are processed as 128/esize lanes. When `wide_i`=0, only bits [63:0] are processed, as 64/esize lanes.
- R6: When `wide_i`=0, out_vec_o[127:64] equals dst_vec_i[127:64] of the same request.
- R7: When imm[6:3] is 0000, out_bad_o is 1 and out_vec_o equals the whole of dst_vec_i. For a valid immediate, out_bad_o is 0.
- R8: out_valid_o is in_valid_i delayed by one cycle. out_vec_o and out_bad_o change only in the cycle after an accepted request, and hold their values otherwise.
- R9: While reset is high, and right after it, out_valid_o, out_bad_o and out_vec_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Request strobe |
| wide_i | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| imm_i | input | 7 | Packed element size and shift immediate |
| src_vec_i | input | 128 | Source vector |
| dst_vec_i | input | 128 | Old destination vector |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| out_bad_o | output | 1 | Immediate carried no size bit |
| out_vec_o | output | 128 | New destination vector |

## Verification
A wrong decode of the immediate shows up at the ports in the same result cycle. Every lane boundary moves, or the kept low field grows or shrinks, so whole groups of bytes differ from the expected vector. A mask that is off by one corrupts the bit just above or just below the insertion point in every lane. The bench reaches those bits with all-ones source and all-zero destination patterns, and with the reverse. A fault in the output register or in the width merge shows one cycle after the request: either the upper half changes in narrow mode, or the output changes during idle cycles.

// File: rtl/sli_pkg.sv
package sli_pkg;

    localparam int VEC_W = 128;
    localparam int IMM_W = 7;
    localparam int SH_W  = 6;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    typedef struct packed {
        esz_e            esz;
        logic [SH_W-1:0] shamt;
        logic            ok;
    } imm_dec_t;

    function automatic int esz_bits(esz_e e);
        return 8 << int'(e);
    endfunction

endpackage

// File: rtl/sli_imm_decode.sv
module sli_imm_decode
    import sli_pkg::*;
(
    input  logic [IMM_W-1:0] imm,
    output imm_dec_t         dec
);

    always_comb begin
        dec.ok    = 1'b1;
        dec.esz   = ESZ_8;
        dec.shamt = '0;
        if (imm[6]) begin
            dec.esz   = ESZ_64;
            dec.shamt = imm[5:0];
        end else if (imm[5]) begin
            dec.esz   = ESZ_32;
            dec.shamt = {1'b0, imm[4:0]};
        end else if (imm[4]) begin
            dec.esz   = ESZ_16;
            dec.shamt = {2'b00, imm[3:0]};
        end else if (imm[3]) begin
            dec.esz   = ESZ_8;
            dec.shamt = {3'b000, imm[2:0]};
        end else begin
            dec.ok = 1'b0;
        end
    end

    // R3: a decoded shift never reaches the element width
    always_comb begin
        if (dec.ok) begin
            assert_shift_in_range_R3: assert (int'(dec.shamt) < esz_bits(dec.esz));
        end
    end

endmodule

// File: rtl/sli_lane.sv
module sli_lane #(
    parameter int EW = 8,
    localparam int SHW = $clog2(EW)
) (
    input  logic [EW-1:0]  src,
    input  logic [EW-1:0]  dst,
    input  logic [SHW-1:0] sh,
    output logic [EW-1:0]  res
);

    logic [EW-1:0] keep_mask;

    always_comb begin
        keep_mask = ~({EW{1'b1}} << sh);
        res       = (src << sh) | (dst & keep_mask);
    end

    always_comb begin
        if (sh == '0) begin
            assert_zero_shift_R2: assert (res == src);
        end
        assert_upper_from_src_R1: assert ((res >> sh) == (src & ({EW{1'b1}} >> sh)));
    end

endmodule

// File: rtl/sli_size_bank.sv
module sli_size_bank #(
    parameter int EW = 8,
    parameter int VW = 128,
    localparam int LANES = VW / EW,
    localparam int SHW = $clog2(EW)
) (
    input  logic [VW-1:0] src,
    input  logic [VW-1:0] dst,
    input  logic [5:0]    shamt,
    output logic [VW-1:0] res
);

    logic [SHW-1:0] sh_l;
    assign sh_l = shamt[SHW-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sli_lane #(.EW(EW)) u_lane (
            .src (src[l*EW +: EW]),
            .dst (dst[l*EW +: EW]),
            .sh  (sh_l),
            .res (res[l*EW +: EW])
        );
    end

endmodule

// File: rtl/sli_insert_unit.sv
module sli_insert_unit
    import sli_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid_i,
    input  logic               wide_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [VEC_W-1:0]   src_vec_i,
    input  logic [VEC_W-1:0]   dst_vec_i,
    output logic               out_valid_o,
    output logic               out_bad_o,
    output logic [VEC_W-1:0]   out_vec_o
);

    localparam int HALF_W = VEC_W / 2;
    localparam int N_SIZE = 4;

    imm_dec_t         dec;
    logic [VEC_W-1:0] bank_res [N_SIZE];
    logic [VEC_W-1:0] sel_res;
    logic [VEC_W-1:0] next_vec;

    sli_imm_decode u_dec (
        .imm (imm_i),
        .dec (dec)
    );

    for (genvar s = 0; s < N_SIZE; s++) begin : g_size
        sli_size_bank #(.EW(8 << s), .VW(VEC_W)) u_bank (
            .src   (src_vec_i),
            .dst   (dst_vec_i),
            .shamt (dec.shamt),
            .res   (bank_res[s])
        );
    end

    always_comb begin
        sel_res = bank_res[int'(dec.esz)];
        if (!dec.ok) begin
            next_vec = dst_vec_i;
        end else if (wide_i) begin
            next_vec = sel_res;
        end else begin
            next_vec = {dst_vec_i[VEC_W-1:HALF_W], sel_res[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_bad_o   <= 1'b0;
            out_vec_o   <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_bad_o <= ~dec.ok;
                out_vec_o <= next_vec;
            end
        end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> ($stable(out_vec_o) && $stable(out_bad_o)));
    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !wide_i) |=> out_vec_o[VEC_W-1:HALF_W] == $past(dst_vec_i[VEC_W-1:HALF_W]));
    assert_bad_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && imm_i[6:3] == 4'b0000) |=> (out_bad_o && out_vec_o == $past(dst_vec_i)));

endmodule

// File: tb/sli_insert_unit_tb.sv
module sli_insert_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid_i;
    logic         wide_i;
    logic [6:0]   imm_i;
    logic [127:0] src_vec_i;
    logic [127:0] dst_vec_i;
    logic         out_valid_o;
    logic         out_bad_o;
    logic [127:0] out_vec_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sli_insert_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid_i),
        .wide_i      (wide_i),
        .imm_i       (imm_i),
        .src_vec_i   (src_vec_i),
        .dst_vec_i   (dst_vec_i),
        .out_valid_o (out_valid_o),
        .out_bad_o   (out_bad_o),
        .out_vec_o   (out_vec_o)
    );

    function automatic logic [127:0] model(input logic w, input logic [6:0] imm,
                                           input logic [127:0] s, input logic [127:0] d);
        int es;
        int sh;
        int n;
        logic [127:0] em;
        logic [127:0] r;
        if (imm[6]) begin es = 64; sh = int'(imm[5:0]); end
        else if (imm[5]) begin es = 32; sh = int'(imm[4:0]); end
        else if (imm[4]) begin es = 16; sh = int'(imm[3:0]); end
        else if (imm[3]) begin es = 8;  sh = int'(imm[2:0]); end
        else return d;
        em = (128'd1 << es) - 128'd1;
        n  = (w ? 128 : 64) / es;
        r  = d;
        for (int e = 0; e < n; e++) begin
            logic [127:0] se;
            logic [127:0] de;
            logic [127:0] v;
            se = (s >> (e*es)) & em;
            de = (d >> (e*es)) & em;
            v  = ((se << sh) & em) | (de & ((128'd1 << sh) - 128'd1));
            r  = (r & ~(em << (e*es))) | (v << (e*es));
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s vec act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s bit act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic w, input logic [6:0] imm,
                          input logic [127:0] s, input logic [127:0] d);
        in_valid_i = 1'b1;
        wide_i     = w;
        imm_i      = imm;
        src_vec_i  = s;
        dst_vec_i  = d;
        @(negedge clk);
        in_valid_i = 1'b0;
        check_bit({tag, " R8 valid"}, out_valid_o, 1'b1);
        check_bit({tag, " R7 flag"}, out_bad_o, imm[6:3] == 4'b0000);
        check_vec(tag, out_vec_o, model(w, imm, s, d));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'h1f2e3d4c));
        rst = 1'b1; in_valid_i = 1'b0; wide_i = 1'b1; imm_i = '0;
        src_vec_i = '0; dst_vec_i = '0;
        repeat (3) @(negedge clk);
        check_bit("R9 valid in reset", out_valid_o, 1'b0);
        check_bit("R9 flag in reset", out_bad_o, 1'b0);
        check_vec("R9 vec in reset", out_vec_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R9 valid after reset", out_valid_o, 1'b0);

        // R1 hand value: bytes, shift 4, AB over CD -> BD
        run_op("R1 byte", 1'b1, 7'h0C, {16{8'hAB}}, {16{8'hCD}});
        check_vec("R1 literal", out_vec_o, {16{8'hBD}});
        // R2 zero shift for each size
        run_op("R2 s8",  1'b1, 7'h08, rnd128(), rnd128());
        run_op("R2 s16", 1'b1, 7'h10, rnd128(), rnd128());
        run_op("R2 s32", 1'b1, 7'h20, rnd128(), rnd128());
        run_op("R2 s64", 1'b1, 7'h40, rnd128(), rnd128());
        check_vec("R2 equals src", out_vec_o, src_vec_i);
        // R3 maximum shifts per size
        run_op("R3 s8 max",  1'b1, 7'h0F, rnd128(), rnd128());
        run_op("R3 s16 max", 1'b1, 7'h1F, rnd128(), rnd128());
        run_op("R3 s32 max", 1'b1, 7'h3F, rnd128(), rnd128());
        run_op("R3 s64 max", 1'b1, 7'h7F, rnd128(), rnd128());
        // R4 overflow dropped, no lane crosstalk
        run_op("R4 ones src", 1'b1, 7'h0D, {128{1'b1}}, '0);
        check_vec("R4 literal", out_vec_o, {16{8'hE0}});
        run_op("R4 ones dst", 1'b1, 7'h13, '0, {128{1'b1}});
        check_vec("R4 literal dst", out_vec_o, {8{16'h0007}});
        // R5/R6 narrow mode
        run_op("R5 narrow s32", 1'b0, 7'h27, rnd128(), rnd128());
        check_vec("R6 upper kept", {out_vec_o[127:64], 64'h0}, {dst_vec_i[127:64], 64'h0});
        run_op("R5 narrow s64", 1'b0, 7'h45, rnd128(), rnd128());
        // R7 invalid immediate
        run_op("R7 bad", 1'b1, 7'h05, rnd128(), rnd128());
        check_vec("R7 passthru", out_vec_o, dst_vec_i);
        run_op("R7 bad narrow", 1'b0, 7'h00, rnd128(), rnd128());
        // R8 hold when idle
        held = out_vec_o;
        src_vec_i = rnd128(); dst_vec_i = rnd128(); imm_i = 7'h4A;
        @(negedge clk);
        check_bit("R8 idle valid", out_valid_o, 1'b0);
        check_vec("R8 idle hold", out_vec_o, held);
        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [6:0] im;
            int sz;
            sz = int'($urandom() % 5);
            if (sz == 4) im = 7'($urandom());
            else im = 7'((1 << (sz + 3)) | ($urandom() % (8 << sz)));
            run_op("R1 random", 1'($urandom()), im, rnd128(), rnd128());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule